// File: doc/BRIEF.md
# Host Command/Data Port Engine for an Embedded Controller

This block is the host-facing side of an embedded controller's command and data port pair. The host writes opcode bytes to a command port and address or value bytes to a data port. A small state machine sequences those bytes into register reads, register writes, burst-mode changes and event queries. A single output byte carries results back to the host. A status byte reports the handshake flags, the burst state and whether any event is pending.

The host address space has two parts. Addresses below 0x20 hold a small register file: a fixed layout version, a test byte with its complement, and general scratch bytes. Addresses 0x20 to 0xFF form a read-only window onto a 224-byte shared memory that local logic fills through its own write port. Local writes marked as part of a multi-byte value are deferred while burst mode is on, so the host never reads a half-updated value. Deferred writes are applied in order once burst mode ends. A 32-bit pending-event register collects local event pulses. The query opcode drains it one event at a time, lowest bit first.

State machine states: `S_IDLE` (no sequence open), `S_RD_ADDR` (read opcode taken, waiting for the address), `S_WR_ADDR` (write opcode taken, waiting for the address) and `S_WR_DATA` (write address taken, waiting for the value). Transitions:
- A read opcode moves the machine to `S_RD_ADDR`, and a write opcode moves it to `S_WR_ADDR`. Both happen from any state.
- A data byte in `S_RD_ADDR` loads the result and returns to `S_IDLE`.
- A data byte in `S_WR_ADDR` latches the address and moves to `S_WR_DATA`.
- A data byte in `S_WR_DATA` performs the write and returns to `S_IDLE`.
- Burst-on, burst-off, query and unknown opcodes return the machine to `S_IDLE` from any state.

Top module: `ec_host_port`

## Requirements
- R1: Read sequence. The host writes opcode 0x80 to the command port, then an address byte to the data port. One clock after that address byte is consumed, `host_rdata` holds the addressed value and status bit 0 (output full) is 1. A `host_data_rd` pulse clears status bit 0.
- R2: Write sequence. The host writes opcode 0x81, then an address byte, then a value byte, all to the data port except the opcode. The value is stored at addresses 0x03 to 0x1F and reads back unchanged. Host writes to 0x00, 0x02 and 0x20 to 0xFF change nothing.
- R3: Address 0x00 reads 0x02. Writing value v to address 0x01 makes address 0x02 read 0xFF minus v.
- R4: Status bit 1 (input full) is 1 in the cycle after any host write and clears one cycle later. Status bit 3 is 1 when the last host write was to the command port and 0 when it was to the data port. Status bit 2 (processing) is 1 while a byte is unconsumed or a sequence is open.
- R5: A host read of address a, for a from 0x20 to 0xFF, returns shared memory offset a minus 0x20. Local writes to offsets 0xE0 and above change nothing.
- R6: Opcode 0x82 sets status bit 4 (burst). Opcode 0x83 clears it.
- R7: Queuing of local writes. A local write is queued, not applied, in two cases: it is flagged multi-byte while burst is on, or the queue is non-empty. Otherwise it is applied at once. When burst is off, queued writes are applied in arrival order, one per clock. A write that arrives while the 4-entry queue is full is discarded.
- R8: Opcode 0x84 clears the lowest set pending-event bit and returns its 1-based index (bit 0 gives 1, bit 31 gives 32), or 0 when no event is pending. The result appears in `host_rdata` with status bit 0 set. Status bit 5 is 1 exactly when any event is pending.
- R9: A command byte arriving mid-sequence abandons the open sequence. A data byte with no open sequence, and any opcode outside 0x80 to 0x84, has no effect.
- R10: After reset, `host_status` and `host_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd_wr | input | 1 | Host write strobe for the command port |
| host_data_wr | input | 1 | Host write strobe for the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_data_rd | input | 1 | Host read strobe for the data port |
| host_rdata | output | 8 | Result byte for the host |
| host_status | output | 8 | Status byte (bits 0 to 5 as in R1, R4, R6 and R8) |
| evt_set | input | 32 | Local event pulses, OR'd into the pending register |
| loc_wr | input | 1 | Local shared-memory write strobe |
| loc_multi | input | 1 | Local write belongs to a multi-byte value |
| loc_addr | input | 8 | Local write offset |
| loc_wdata | input | 8 | Local write value |

## Verification
The hardest case to reach is the burst interlock, both with and without a full queue. The bench first turns burst on with a host opcode. It then writes one single-byte local value and two multi-byte values to the same offset, and reads the window to show the old value is still there. After the burst-off opcode, it reads again to show the later value wins. A second burst pass pushes five deferred writes into the four-entry queue, then reads all five offsets to show the fifth was dropped. Aborted sequences are reached by issuing a write opcode and address, then issuing a read opcode before the value byte.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_RD_ADDR,
        S_WR_ADDR,
        S_WR_DATA
    } port_state_e;

    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;

    localparam logic [7:0] LAYOUT_VERSION = 8'd2;

    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_PROC  = 2;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;
    localparam int ST_EVT   = 5;
endpackage

// File: rtl/ecp_event_query.sv
module ecp_event_query #(
    parameter int EVT_W = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_set,
    input  logic             take,
    output logic             any_pending,
    output logic [IDX_W-1:0] low_idx
);
    logic [EVT_W-1:0] pend_q;
    logic [EVT_W-1:0] low_mask;

    // Scan from the top so the lowest set bit is the last to assign.
    always_comb begin
        low_idx  = '0;
        low_mask = '0;
        for (int i = EVT_W - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                low_idx  = IDX_W'(i + 1);
                low_mask = '0;
                low_mask[i] = 1'b1;
            end
        end
    end

    assign any_pending = |pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~(take ? low_mask : '0)) | evt_set;
        end
    end
endmodule

// File: rtl/ecp_reg_space.sv
module ecp_reg_space #(
    parameter int TOP_ADDR = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       we,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data
);
    import ecp_pkg::*;

    localparam int FIRST_SCR = 3;
    localparam int NUM_SCR   = TOP_ADDR - FIRST_SCR;

    logic [7:0] test_q;
    logic [7:0] compl_q;
    logic [7:0] scr_q [NUM_SCR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q  <= 8'h00;
            compl_q <= 8'hFF;
            for (int k = 0; k < NUM_SCR; k++) scr_q[k] <= 8'h00;
        end else if (we) begin
            if (wr_addr == 8'h01) begin
                test_q  <= wr_data;
                compl_q <= 8'hFF - wr_data;
            end
            for (int k = 0; k < NUM_SCR; k++) begin
                if (wr_addr == 8'(FIRST_SCR + k)) scr_q[k] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == 8'h00)      rd_data = LAYOUT_VERSION;
        else if (rd_addr == 8'h01) rd_data = test_q;
        else if (rd_addr == 8'h02) rd_data = compl_q;
        for (int k = 0; k < NUM_SCR; k++) begin
            if (rd_addr == 8'(FIRST_SCR + k)) rd_data = scr_q[k];
        end
    end
endmodule

// File: rtl/ecp_shared_mem.sv
module ecp_shared_mem #(
    parameter int MAP_SIZE   = 224,
    parameter int HOLD_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_en,
    input  logic       loc_wr,
    input  logic       loc_multi,
    input  logic [7:0] loc_addr,
    input  logic [7:0] loc_wdata,
    input  logic [7:0] rd_off,
    output logic [7:0] rd_data
);
    localparam int PTR_W = (HOLD_DEPTH > 1) ? $clog2(HOLD_DEPTH) : 1;
    localparam int CNT_W = $clog2(HOLD_DEPTH + 1);

    logic [7:0]       mem_q [MAP_SIZE];
    logic [7:0]       q_addr [HOLD_DEPTH];
    logic [7:0]       q_data [HOLD_DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;

    logic in_range, queue_it, direct, push, pop;

    assign in_range = loc_addr < 8'(MAP_SIZE);
    assign queue_it = loc_wr && in_range && ((hold_en && loc_multi) || (cnt_q != '0));
    assign direct   = loc_wr && in_range && !queue_it;
    assign push     = queue_it && (cnt_q < CNT_W'(HOLD_DEPTH));
    assign pop      = !hold_en && (cnt_q != '0);

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(HOLD_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAP_SIZE; k++) mem_q[k] <= 8'h00;
            for (int k = 0; k < HOLD_DEPTH; k++) begin
                q_addr[k] <= 8'h00;
                q_data[k] <= 8'h00;
            end
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (direct) mem_q[loc_addr] <= loc_wdata;
            else if (pop) mem_q[q_addr[rp_q]] <= q_data[rp_q];
            if (push) begin
                q_addr[wp_q] <= loc_addr;
                q_data[wp_q] <= loc_wdata;
                wp_q <= bump(wp_q);
            end
            if (pop) rp_q <= bump(rp_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign rd_data = (rd_off < 8'(MAP_SIZE)) ? mem_q[rd_off] : 8'h00;
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port #(
    parameter int WIN_BASE   = 32,
    parameter int HOLD_DEPTH = 4,
    parameter int EVT_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cmd_wr,
    input  logic             host_data_wr,
    input  logic [7:0]       host_wdata,
    input  logic             host_data_rd,
    output logic [7:0]       host_rdata,
    output logic [7:0]       host_status,
    input  logic [EVT_W-1:0] evt_set,
    input  logic             loc_wr,
    input  logic             loc_multi,
    input  logic [7:0]       loc_addr,
    input  logic [7:0]       loc_wdata
);
    import ecp_pkg::*;

    localparam int MAP_SIZE = 256 - WIN_BASE;

    port_state_e state_q, state_d;
    logic       ibf_q, last_cmd_q, obf_q, burst_q;
    logic [7:0] ib_q, obuf_q, wr_addr_q;

    logic       act_reg_we, act_load, act_burst_on, act_burst_off, act_query, act_lat_addr;
    logic [7:0] act_value;

    logic       win_hit;
    logic [7:0] reg_rd, shm_rd, rd_val, qry_idx;
    logic       evt_any;

    assign win_hit = ib_q >= 8'(WIN_BASE);
    assign rd_val  = win_hit ? shm_rd : reg_rd;

    // Next-state and action decode.
    always_comb begin
        state_d       = state_q;
        act_reg_we    = 1'b0;
        act_load      = 1'b0;
        act_value     = 8'h00;
        act_burst_on  = 1'b0;
        act_burst_off = 1'b0;
        act_query     = 1'b0;
        act_lat_addr  = 1'b0;
        if (ibf_q) begin
            if (last_cmd_q) begin
                case (ib_q)
                    OP_READ:      state_d = S_RD_ADDR;
                    OP_WRITE:     state_d = S_WR_ADDR;
                    OP_BURST_ON:  begin state_d = S_IDLE; act_burst_on = 1'b1; end
                    OP_BURST_OFF: begin state_d = S_IDLE; act_burst_off = 1'b1; end
                    OP_QUERY: begin
                        state_d   = S_IDLE;
                        act_query = 1'b1;
                        act_load  = 1'b1;
                        act_value = qry_idx;
                    end
                    default:      state_d = S_IDLE;
                endcase
            end else begin
                unique case (state_q)
                    S_IDLE:    state_d = S_IDLE;
                    S_RD_ADDR: begin
                        state_d   = S_IDLE;
                        act_load  = 1'b1;
                        act_value = rd_val;
                    end
                    S_WR_ADDR: begin
                        state_d      = S_WR_DATA;
                        act_lat_addr = 1'b1;
                    end
                    S_WR_DATA: begin
                        state_d    = S_IDLE;
                        act_reg_we = wr_addr_q < 8'(WIN_BASE);
                    end
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output and handshake registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf_q      <= 1'b0;
            last_cmd_q <= 1'b0;
            ib_q       <= 8'h00;
            obf_q      <= 1'b0;
            obuf_q     <= 8'h00;
            burst_q    <= 1'b0;
            wr_addr_q  <= 8'h00;
        end else begin
            if (host_cmd_wr || host_data_wr) begin
                ibf_q      <= 1'b1;
                ib_q       <= host_wdata;
                last_cmd_q <= host_cmd_wr;
            end else if (ibf_q) begin
                ibf_q <= 1'b0;
            end
            if (act_load) begin
                obf_q  <= 1'b1;
                obuf_q <= act_value;
            end else if (host_data_rd) begin
                obf_q <= 1'b0;
            end
            if (act_burst_on)       burst_q <= 1'b1;
            else if (act_burst_off) burst_q <= 1'b0;
            if (act_lat_addr) wr_addr_q <= ib_q;
        end
    end

    ecp_reg_space #(.TOP_ADDR(WIN_BASE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (ib_q),
        .rd_data (reg_rd),
        .we      (act_reg_we),
        .wr_addr (wr_addr_q),
        .wr_data (ib_q)
    );

    ecp_shared_mem #(.MAP_SIZE(MAP_SIZE), .HOLD_DEPTH(HOLD_DEPTH)) u_shm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_en   (burst_q),
        .loc_wr    (loc_wr),
        .loc_multi (loc_multi),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .rd_off    (ib_q - 8'(WIN_BASE)),
        .rd_data   (shm_rd)
    );

    ecp_event_query #(.EVT_W(EVT_W), .IDX_W(8)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_set     (evt_set),
        .take        (act_query),
        .any_pending (evt_any),
        .low_idx     (qry_idx)
    );

    assign host_rdata = obuf_q;

    always_comb begin
        host_status           = 8'h00;
        host_status[ST_OBF]   = obf_q;
        host_status[ST_IBF]   = ibf_q;
        host_status[ST_PROC]  = ibf_q || (state_q != S_IDLE);
        host_status[ST_CMD]   = last_cmd_q;
        host_status[ST_BURST] = burst_q;
        host_status[ST_EVT]   = evt_any;
    end
endmodule

// File: rtl/ec_host_port_checker.sv
module ec_host_port_checker #(
    parameter int EVT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_cmd_wr,
    input logic             host_data_wr,
    input logic [7:0]       host_status,
    input logic [EVT_W-1:0] evt_set
);
    // R4: input-full clears one cycle after it is seen if no new write arrives
    a_r4_ibf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_status[1] && !host_cmd_wr && !host_data_wr) |=> !host_status[1]);

    // R4: a command-port write marks the last write as a command
    a_r4_last_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        host_cmd_wr |=> host_status[3]);

    // R1: output-full only rises after an input byte was being consumed
    a_r1_obf_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_status[0]) |-> $past(host_status[1]));

    // R6: burst only turns on after a command byte was consumed
    a_r6_burst_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_status[4]) |-> $past(host_status[3] && host_status[1]));

    // R8: any event pulse leaves the pending flag set
    a_r8_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> host_status[5]);

    // R8: the pending flag only drops after a command was consumed
    a_r8_flag_drop_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_status[5]) |-> $past(host_status[3] && host_status[1]));
endmodule

bind ec_host_port ec_host_port_checker #(.EVT_W(EVT_W)) u_chk (.*);

// File: tb/ec_host_port_bench.sv
module ec_host_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cmd_wr = 1'b0, host_data_wr = 1'b0, host_data_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata, host_status;
    logic [31:0] evt_set = '0;
    logic        loc_wr = 1'b0, loc_multi = 1'b0;
    logic [7:0]  loc_addr = 8'h00, loc_wdata = 8'h00;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [7:0] mid_status;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ec_host_port u_ec_host_port (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input bit is_cmd, input logic [7:0] b);
        @(negedge clk);
        host_cmd_wr  = is_cmd;
        host_data_wr = !is_cmd;
        host_wdata   = b;
        @(negedge clk);
        host_cmd_wr  = 1'b0;
        host_data_wr = 1'b0;
        mid_status   = host_status;
        @(negedge clk);
    endtask

    task automatic host_take(output logic [7:0] v);
        v = host_rdata;
        host_data_rd = 1'b1;
        @(negedge clk);
        host_data_rd = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] v);
        host_wr(1'b1, 8'h80);
        host_wr(1'b0, a);
        host_take(v);
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        host_wr(1'b1, 8'h81);
        host_wr(1'b0, a);
        host_wr(1'b0, d);
    endtask

    task automatic local_wr(input bit multi, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        loc_wr = 1'b1; loc_multi = multi; loc_addr = a; loc_wdata = d;
        @(negedge clk);
        loc_wr = 1'b0; loc_multi = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 status after reset", host_status, 8'h00);
        chk("R10 rdata after reset", host_rdata, 8'h00);
    endtask

    task automatic t_version();
        logic [7:0] v;
        host_wr(1'b1, 8'h80);
        host_wr(1'b0, 8'h00);
        chk("R1 output full after read", host_status[0], 1'b1);
        host_take(v);
        chk("R3 version byte", v, 8'h02);
        chk("R1 output full cleared by read", host_status[0], 1'b0);
    endtask

    task automatic t_test_byte();
        logic [7:0] v;
        host_write(8'h01, 8'h35);
        host_read(8'h02, v);
        chk("R3 complement of test byte", v, 8'hCA);
        host_write(8'h02, 8'h11);
        host_read(8'h02, v);
        chk("R2 write to complement ignored", v, 8'hCA);
    endtask

    task automatic t_scratch();
        logic [7:0] v;
        host_write(8'h05, 8'hA5);
        host_write(8'h1F, 8'h3C);
        host_read(8'h05, v);
        chk("R2 scratch 0x05", v, 8'hA5);
        host_read(8'h1F, v);
        chk("R2 scratch 0x1F", v, 8'h3C);
        host_write(8'h00, 8'h77);
        host_read(8'h00, v);
        chk("R2 version not writable", v, 8'h02);
        host_write(8'h30, 8'h99);
        host_read(8'h30, v);
        chk("R2 window read-only", v, 8'h00);
    endtask

    task automatic t_status();
        host_wr(1'b1, 8'h81);
        chk("R4 input full mid-write", mid_status[1], 1'b1);
        chk("R4 last write was command", host_status[3], 1'b1);
        chk("R4 processing during sequence", host_status[2], 1'b1);
        chk("R4 input full consumed", host_status[1], 1'b0);
        host_wr(1'b0, 8'h06);
        chk("R4 last write was data", host_status[3], 1'b0);
        host_wr(1'b0, 8'h42);
        chk("R4 processing idle after write", host_status[2], 1'b0);
    endtask

    task automatic t_window();
        logic [7:0] v;
        local_wr(1'b0, 8'h10, 8'h5A);
        host_read(8'h30, v);
        chk("R5 window offset 0x10", v, 8'h5A);
        local_wr(1'b0, 8'hDF, 8'h66);
        local_wr(1'b0, 8'hE0, 8'h12);
        local_wr(1'b0, 8'hFF, 8'h13);
        host_read(8'hFF, v);
        chk("R5 top of window unaffected by out-of-range", v, 8'h66);
        host_read(8'h20, v);
        chk("R5 window base", v, 8'h00);
    endtask

    task automatic t_burst();
        logic [7:0] v;
        host_wr(1'b1, 8'h82);
        chk("R6 burst bit set", host_status[4], 1'b1);
        local_wr(1'b0, 8'h06, 8'h33);
        host_read(8'h26, v);
        chk("R7 single-byte applied in burst", v, 8'h33);
        local_wr(1'b1, 8'h04, 8'h11);
        local_wr(1'b1, 8'h04, 8'h12);
        host_read(8'h24, v);
        chk("R7 multi-byte held in burst", v, 8'h00);
        host_wr(1'b1, 8'h83);
        chk("R6 burst bit cleared", host_status[4], 1'b0);
        repeat (4) @(negedge clk);
        host_read(8'h24, v);
        chk("R7 held writes applied in order", v, 8'h12);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        host_wr(1'b1, 8'h82);
        for (int i = 0; i < 5; i++) local_wr(1'b1, 8'(8'h40 + i), 8'(8'hB0 + i));
        host_wr(1'b1, 8'h83);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            host_read(8'(8'h60 + i), v);
            chk("R7 queued write applied", v, 32'(8'hB0 + i));
        end
        host_read(8'h64, v);
        chk("R7 write dropped when queue full", v, 8'h00);
    endtask

    task automatic t_query();
        logic [7:0] v;
        chk("R8 no pending flag", host_status[5], 1'b0);
        host_wr(1'b1, 8'h84);
        chk("R8 query result loaded", host_status[0], 1'b1);
        host_take(v);
        chk("R8 empty query returns 0", v, 8'h00);
        @(negedge clk);
        evt_set = 32'h8000_0011;
        @(negedge clk);
        evt_set = '0;
        chk("R8 pending flag set", host_status[5], 1'b1);
        host_wr(1'b1, 8'h84); host_take(v);
        chk("R8 bit 0 gives 1", v, 8'd1);
        host_wr(1'b1, 8'h84); host_take(v);
        chk("R8 bit 4 gives 5", v, 8'd5);
        host_wr(1'b1, 8'h84); host_take(v);
        chk("R8 bit 31 gives 32", v, 8'd32);
        chk("R8 pending flag clear", host_status[5], 1'b0);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        host_write(8'h07, 8'h21);
        host_wr(1'b1, 8'h81);
        host_wr(1'b0, 8'h07);
        host_read(8'h07, v);
        chk("R9 aborted write left value", v, 8'h21);
        host_wr(1'b0, 8'h09);
        chk("R9 stray data byte gives no result", host_status[0], 1'b0);
        host_wr(1'b1, 8'h55);
        host_wr(1'b0, 8'h05);
        chk("R9 unknown opcode gives no result", host_status[0], 1'b0);
        chk("R9 unknown opcode leaves idle", host_status[2], 1'b0);
        host_read(8'h09, v);
        chk("R9 stray byte wrote nothing", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_version();
        t_test_byte();
        t_scratch();
        t_status();
        t_window();
        t_burst();
        t_overflow();
        t_query();
        t_abort();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule